// File: doc/BRIEF.md
# Multi-rate synchronous trigger generator

This block turns one 10 MHz reference clock into a family of phase-locked trigger strobes for data acquisition. A programmable base divisor sets the fastest rate. Four secondary channels each fire on every M-th base strobe, with M set per channel. Because every secondary channel counts base strobes and not reference cycles, each slower trigger lands in the same cycle as a base trigger. The sampling schedule therefore follows from the shared reference clock alone and repeats exactly from one run to the next.

The base strobe drives a backplane trigger line. The same strobe also goes out on a separate port that starts the acquisition sequencer. Software loads the divisors and the enables through a small write-only register port. Divisor writes go to holding registers and reach the counters only at a period boundary. A synchronous restart input clears every counter at once, so that several chassis fed from one clock and one restart line begin counting in step.

All logic runs on the reference clock, and the restart input is assumed to be synchronous to it.

Top module: `rate_trigger_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `trig_base`, `seq_start` and every bit of `trig_sub` are 0, the block is disabled, and every held divisor and multiplier value is 0.
- R2: With an active base divisor N of 2 or more and the block running, `trig_base` is high for exactly one cycle in every N cycles.
- R3: A base divisor of 0 or 1 makes `trig_base` high in every cycle while the block is running.
- R4: Channel k (k = 0..3) with multiplier M fires `trig_sub[k]` on every M-th base strobe, in the same cycle as that base strobe. M of 0 behaves like 1.
- R5: A divisor or multiplier write takes effect only at the next base strobe. The interval in progress completes with the old value. While the block is idle, new values take effect at once.
- R6: While `sync_in` is high, all outputs are 0 and all counters are held at zero. After `sync_in` falls, the first base strobe appears N cycles later, counted from the first clock edge with `sync_in` low, and the channels restart their counts from zero.
- R7: Control bit 0 is the global enable. While it is 0, all outputs are 0 and the counters are held at zero. After it is set, the first base strobe appears N cycles after the first edge that sees the bit set.
- R8: Control bits 4..1 enable the outputs of channels 0..3. A cleared bit forces that channel's output to 0, but its count keeps running so that it stays in phase.
- R9: `seq_start` equals `trig_base` in every cycle.
- R10: Address map: 0 holds the base divisor (data bits 23:0). Addresses 1 to 4 hold the multipliers of channels 0 to 3 (data bits 15:0). Address 7 is the control register. Writes to addresses 5 and 6 have no effect.
- R11: When a channel's multiplier is lowered below the count the channel has already reached, the channel fires at the next base strobe after the new value takes effect and then continues at the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 24 | Register write data |
| sync_in | input | 1 | Restart of all counters, synchronous to clk |
| trig_base | output | 1 | Base-rate trigger strobe for the backplane line |
| seq_start | output | 1 | Sequencer start strobe, same timing as trig_base |
| trig_sub | output | 4 | Secondary-rate strobes, one per channel |

## Verification
The hardest case to reach from the ports is a value change that lands partway through a period. Examples are a base divisor written after a few cycles of an interval, or a multiplier lowered after the channel has already counted past the new value. To hit these, the bench restarts all counters with a `sync_in` pulse and counts clock cycles from its release. It then issues the write at a chosen cycle, so the point reached in the interval is known exactly. The bench then records the cycle index of each following strobe. A cycle-by-cycle behavioural model runs alongside and checks the phase of every channel as values change, as the restart is applied and as channels are masked.

// File: rtl/rtg_pkg.sv
// Package: shared register map constants for the multi-rate trigger generator.
// Assumes: the control register sits at the top address of the map.
package rtg_pkg;
    localparam int RTG_ADDR_BASE = 0;   // base divisor register
    localparam int RTG_ADDR_CH0  = 1;   // first channel multiplier, channels follow
    localparam int RTG_CTRL_EN   = 0;   // control bit: global enable
    localparam int RTG_CTRL_CH0  = 1;   // control bit: channel 0 output enable
endpackage

// File: rtl/rtg_cfg_regs.sv
// Module: rtg_cfg_regs
// Holds the software-written values: the base divisor and channel multiplier
// holding registers, the global enable and the per-channel output enables.
// Assumes: NCH + 2 <= 2**ADDR_W and MULT_W, NCH + 1 <= DATA_W.
module rtg_cfg_regs
    import rtg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 24,
    parameter int MULT_W = 16,
    parameter int NCH    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic [DATA_W-1:0]             base_hold,
    output logic [NCH-1:0][MULT_W-1:0]    mult_hold,
    output logic                          en_q,
    output logic [NCH-1:0]                chen_q
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(RTG_ADDR_BASE);

    // Purpose: decode a write and update the addressed holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hold <= '0;
            mult_hold <= '0;
            en_q      <= 1'b0;
            chen_q    <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == BASE_ADDR) begin
                base_hold <= cfg_wdata;
            end
            if (cfg_addr == CTRL_ADDR) begin
                en_q   <= cfg_wdata[RTG_CTRL_EN];
                chen_q <= cfg_wdata[RTG_CTRL_CH0 +: NCH];
            end
            for (int k = 0; k < NCH; k++) begin
                if (cfg_addr == ADDR_W'(RTG_ADDR_CH0 + k)) begin
                    mult_hold[k] <= cfg_wdata[MULT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/rtg_base_div.sv
// Module: rtg_base_div
// Divides the reference clock by the active base divisor and emits a
// registered one-cycle tick. It moves the held divisor into the active
// register at each period boundary, and continuously while idle.
// Assumes: run is low whenever the block is disabled or restarting.
module rtg_base_div #(
    parameter int BASE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BASE_W-1:0] div_hold,
    output logic              tick,
    output logic              wrap,
    output logic              reload
);
    logic [BASE_W-1:0] div_act;
    logic [BASE_W-1:0] cnt;
    logic              last;

    // Purpose: flag the final cycle of a period (divisor 0 or 1 means every cycle).
    always_comb begin
        last = (div_act <= BASE_W'(1)) || (cnt == div_act - BASE_W'(1));
    end

    assign wrap   = run && last;
    assign reload = !run || last;

    // Purpose: advance the period counter and register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= last;
            cnt  <= last ? '0 : cnt + BASE_W'(1);
        end
    end

    // Purpose: take the held divisor only at a period boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act <= '0;
        end else if (reload) begin
            div_act <= div_hold;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act > BASE_W'(1)) |-> (cnt < div_act)); // R2
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || ($past(div_act) <= BASE_W'(1)))); // R3
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(div_act)); // R5
endmodule

// File: rtl/rtg_sub_chan.sv
// Module: rtg_sub_chan
// One secondary channel: counts base-period boundaries and fires on every
// M-th one, in the same cycle as the base tick. The count keeps running
// when the output is masked, so the channel stays in phase.
// Assumes: wrap and reload come from the base divider of the same block.
module rtg_sub_chan #(
    parameter int MULT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wrap,
    input  logic              reload,
    input  logic              base_tick,
    input  logic              out_en,
    input  logic [MULT_W-1:0] mult_hold,
    output logic              strobe
);
    logic [MULT_W-1:0] mult_act;
    logic [MULT_W-1:0] cnt;
    logic              last;

    // Purpose: final base period of this channel's cycle (>= covers a lowered multiplier).
    always_comb begin
        last = (mult_act <= MULT_W'(1)) || (cnt >= mult_act - MULT_W'(1));
    end

    // Purpose: count base boundaries and register the masked strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (!run) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (wrap) begin
            strobe <= last && out_en;
            cnt    <= last ? '0 : cnt + MULT_W'(1);
        end else begin
            strobe <= 1'b0;
        end
    end

    // Purpose: move the held multiplier in at base boundaries or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_act <= '0;
        end else if (reload) begin
            mult_act <= mult_hold;
        end
    end

    AST_SUB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> base_tick); // R4
    AST_SUB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !strobe); // R8
endmodule

// File: rtl/rate_trigger_gen.sv
// Module: rate_trigger_gen
// Top level: register port, base divider and a generated set of secondary
// channels cascaded from the base boundary. sync_in or a cleared enable
// holds every counter at zero.
// Assumes: a single clock; sync_in is synchronous to clk.
module rate_trigger_gen #(
    parameter int ADDR_W = 3,
    parameter int BASE_W = 24,
    parameter int MULT_W = 16,
    parameter int NCH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BASE_W-1:0] cfg_wdata,
    input  logic              sync_in,
    output logic              trig_base,
    output logic              seq_start,
    output logic [NCH-1:0]    trig_sub
);
    logic [BASE_W-1:0]          base_hold;
    logic [NCH-1:0][MULT_W-1:0] mult_hold;
    logic                       en_q;
    logic [NCH-1:0]             chen_q;
    logic                       run;
    logic                       tick;
    logic                       wrap;
    logic                       reload;

    rtg_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (BASE_W),
        .MULT_W (MULT_W),
        .NCH    (NCH)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_hold (base_hold),
        .mult_hold (mult_hold),
        .en_q      (en_q),
        .chen_q    (chen_q)
    );

    // Purpose: counters advance only when enabled and not restarting.
    always_comb begin
        run = en_q && !sync_in;
    end

    rtg_base_div #(
        .BASE_W (BASE_W)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_hold (base_hold),
        .tick     (tick),
        .wrap     (wrap),
        .reload   (reload)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        rtg_sub_chan #(
            .MULT_W (MULT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .wrap      (wrap),
            .reload    (reload),
            .base_tick (tick),
            .out_en    (chen_q[k]),
            .mult_hold (mult_hold[k]),
            .strobe    (trig_sub[k])
        );
    end

    assign trig_base = tick;
    assign seq_start = tick;

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (!trig_base && (trig_sub == '0))); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!trig_base && (trig_sub == '0))); // R7
endmodule

// File: tb/sim_rate_trigger_gen.sv
module sim_rate_trigger_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        sync_in = 1'b0;
    logic        trig_base;
    logic        seq_start;
    logic [3:0]  trig_sub;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    rate_trigger_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sync_in   (sync_in),
        .trig_base (trig_base),
        .seq_start (seq_start),
        .trig_sub  (trig_sub)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_bhold, m_bact, m_cnt, m_ctrl;
    int m_mhold[4], m_mact[4], m_sub[4];
    bit m_tick;
    bit m_stk[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bhold = 0; m_bact = 0; m_cnt = 0; m_ctrl = 0; m_tick = 0;
            for (int k = 0; k < 4; k++) begin
                m_mhold[k] = 0; m_mact[k] = 0; m_sub[k] = 0; m_stk[k] = 0;
            end
        end else begin
            bit going, endp, endc;
            going = m_ctrl[0] && !sync_in;
            endp = (m_bact <= 1) || (m_cnt == m_bact - 1);
            if (!going) begin
                m_cnt = 0; m_tick = 0;
                for (int k = 0; k < 4; k++) begin m_sub[k] = 0; m_stk[k] = 0; end
            end else begin
                m_tick = endp;
                for (int k = 0; k < 4; k++) begin
                    if (endp) begin
                        endc = (m_mact[k] <= 1) || (m_sub[k] >= m_mact[k] - 1);
                        m_stk[k] = endc && m_ctrl[k+1];
                        m_sub[k] = endc ? 0 : m_sub[k] + 1;
                    end else begin
                        m_stk[k] = 0;
                    end
                end
                m_cnt = endp ? 0 : m_cnt + 1;
            end
            if (!going || endp) begin
                m_bact = m_bhold;
                for (int k = 0; k < 4; k++) m_mact[k] = m_mhold[k];
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_bhold = int'(cfg_wdata);
                    3'd1, 3'd2, 3'd3, 3'd4: m_mhold[cfg_addr-1] = int'(cfg_wdata[15:0]);
                    3'd7: m_ctrl = int'(cfg_wdata[4:0]);
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model (R2, R4, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(trig_base == m_tick, "R2 base strobe vs model", trig_base, m_tick);
            chk(seq_start == m_tick, "R9 sequencer start vs model", seq_start, m_tick);
            for (int k = 0; k < 4; k++)
                chk(trig_sub[k] == m_stk[k], "R4 channel strobe vs model", trig_sub[k], m_stk[k]);
        end
    end

    // ---------------- stimulus helpers ----------------
    int w_base, w_seq;
    int w_sub[4];

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d[23:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic win(input int n);
        w_base = 0; w_seq = 0;
        for (int k = 0; k < 4; k++) w_sub[k] = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            w_base += int'(trig_base);
            w_seq += int'(seq_start);
            for (int k = 0; k < 4; k++) w_sub[k] += int'(trig_sub[k]);
        end
    endtask

    task automatic first_base(input int exp, input string req);
        int at;
        at = 0;
        for (int i = 1; i <= exp + 8; i++) begin
            @(negedge clk);
            if (trig_base && at == 0) at = i;
        end
        chk(at == exp, req, at, exp);
    endtask

    task automatic sync_pulse();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #500000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        int s1, s2, s3, ns, c1, c2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(trig_base == 1'b0, "R1 trig_base after reset", trig_base, 0);
        chk(seq_start == 1'b0, "R1 seq_start after reset", seq_start, 0);
        chk(trig_sub == 4'b0, "R1 trig_sub after reset", trig_sub, 0);

        wr(0, 4); wr(1, 2); wr(2, 3); wr(3, 0); wr(4, 1);
        win(8);
        chk(w_base == 0, "R7 no strobes while disabled", w_base, 0);

        wr(7, 'h1F);
        first_base(4, "R7 first strobe after enable");

        // R6: restart
        sync_in = 1'b1;
        win(3);
        chk(w_base == 0, "R6 quiet during sync", w_base, 0);
        chk(w_sub[0] == 0, "R6 channel quiet during sync", w_sub[0], 0);
        sync_in = 1'b0;
        win(24);
        chk(w_base == 6, "R6 base strobes after sync", w_base, 6);
        chk(w_seq == w_base, "R9 seq_start count equals base", w_seq, w_base);
        chk(w_sub[0] == 3, "R4 channel0 M=2", w_sub[0], 3);
        chk(w_sub[1] == 2, "R4 channel1 M=3", w_sub[1], 2);
        chk(w_sub[2] == 6, "R4 channel2 M=0 acts as 1", w_sub[2], 6);
        chk(w_sub[3] == 6, "R4 channel3 M=1", w_sub[3], 6);

        // R5: base divisor written mid-interval
        sync_pulse();
        s1 = 0; s2 = 0; s3 = 0; ns = 0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (i == 2) begin cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 24'd6; end
            if (i == 3) cfg_we = 1'b0;
            if (trig_base) begin
                ns++;
                if (ns == 1) s1 = i; else if (ns == 2) s2 = i; else if (ns == 3) s3 = i;
            end
        end
        chk(s1 == 4, "R5 old period completes", s1, 4);
        chk(s2 == 10, "R5 new period after boundary", s2, 10);
        chk(s3 == 16, "R5 new period repeats", s3, 16);

        // R3: divisor 0 and 1
        wr(0, 0);
        sync_pulse();
        win(8);
        chk(w_base == 8, "R3 divisor 0 every cycle", w_base, 8);
        chk(w_sub[0] == 4, "R3 channel0 on every second", w_sub[0], 4);
        wr(0, 1);
        sync_pulse();
        win(5);
        chk(w_base == 5, "R3 divisor 1 every cycle", w_base, 5);

        // R8: channel output enable
        wr(0, 4);
        wr(7, 'h1D);
        sync_pulse();
        win(24);
        chk(w_sub[0] == 0, "R8 masked channel0 silent", w_sub[0], 0);
        chk(w_sub[1] == 2, "R8 channel1 unaffected", w_sub[1], 2);
        wr(7, 'h1F);
        win(24);
        chk(w_sub[0] == 3, "R8 channel0 resumes in phase", w_sub[0], 3);

        // R10: unused addresses
        sync_in = 1'b1;
        wr(5, 0);
        wr(6, 0);
        sync_in = 1'b0;
        first_base(4, "R10 writes to 5 and 6 ignored");

        // R11: multiplier lowered below current count
        wr(2, 8);
        sync_pulse();
        c1 = 0; c2 = 0;
        for (int i = 1; i <= 48; i++) begin
            @(negedge clk);
            if (i == 21) begin cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 24'd2; end
            if (i == 22) cfg_we = 1'b0;
            if (trig_sub[1]) begin
                if (c1 == 0) c1 = i; else if (c2 == 0) c2 = i;
            end
        end
        chk(c1 == 28, "R11 lowered multiplier fires at next boundary", c1, 28);
        chk(c2 == 36, "R11 then new rate", c2, 36);

        // R7: disable and re-enable
        wr(7, 'h1E);
        win(10);
        chk(w_base == 0, "R7 disabled output quiet", w_base, 0);
        wr(7, 'h1F);
        first_base(4, "R7 re-enable full period");

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule